// File: doc/BRIEF.md
# Virtual Interrupt List Register Controller

This block keeps the list entries that a hypervisor loads to present interrupts to one virtual CPU, together with a hypervisor control word. Software reaches both through a single-cycle register port: a write lands on the next clock edge, and a read returns the addressed word one cycle after the address is presented. Each list entry is 32 bits wide. It carries a two-bit state (pending, active), a five-bit priority, a three-bit source CPU number and a ten-bit virtual interrupt number, plus a few flags that are only stored.

From the stored entries the block derives, without added latency, a set of outputs. The first is the most urgent pending entry: lowest priority value, with the lower slot winning a tie. It also gives the number of pending entries and the number of occupied entries. A lookup port reports the first occupied slot that holds a given virtual interrupt number from a given source CPU. A registered virtual IRQ line tells the CPU that the controller is enabled and that something is pending.

Top module: `virq_list_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four list entries and the control word, so every register reads zero, both counts are 0, `top_valid` and `hit_o` are 0 and `virq` is 0.
- R2: List entry i (i = 0..3) sits at byte offset 0x100 + 4*i and the control word at offset 0x000. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the word addressed in the previous cycle.
- R3: Only implemented bits are stored. These are mask 0xFF881FFF for a list entry and mask 0xF80000FF for the control word. Other bits read back as zero. Offsets other than the five mapped ones read zero, and writes to them change no register.
- R4: In a list entry, bit 28 means pending, bit 29 means active, and bits 29:28 nonzero mean occupied. `pend_cnt` counts entries with bit 28 set. `valid_cnt` counts occupied entries.
- R5: `top_idx` and `top_prio` name the pending entry whose priority (bits 27:23) is numerically smallest, and `top_valid` is 1. When no entry is pending, `top_valid`, `top_idx` and `top_prio` are 0.
- R6: On equal priority the pending entry with the lower slot number wins. Priority value 31 still qualifies.
- R7: `hit_o`/`hit_idx` give the lowest-numbered occupied entry whose bits 9:0 equal `q_vid` and whose bits 12:10 equal `q_cpu`. Unoccupied entries never match, and when nothing matches `hit_o` and `hit_idx` are 0.
- R8: `virq` is a register. It is 1 in the cycle after a clock edge at which control bit 0 was 1 and at least one entry was pending, and 0 otherwise.
- R9: An entry that is active but not pending counts as occupied. It is never chosen by the priority pick and does not raise `virq`.
- R10: Bit 31 of a list entry (the hardware-completion request) is stored and read back. It has no effect on the pick, the lookup, the counts or `virq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| q_vid | input | 10 | Virtual interrupt number to look up |
| q_cpu | input | 3 | Source CPU number to look up |
| hit_o | output | 1 | Lookup found an occupied matching entry |
| hit_idx | output | 2 | Slot of the first matching entry |
| top_valid | output | 1 | At least one entry is pending |
| top_idx | output | 2 | Slot of the most urgent pending entry |
| top_prio | output | 5 | Priority of that entry |
| pend_cnt | output | 3 | Number of pending entries (0..4) |
| valid_cnt | output | 3 | Number of occupied entries (0..4) |
| virq | output | 1 | Virtual IRQ request to the CPU |

## Verification
The most likely internal fault is a wrongly stored entry or control word, caused by a bad mask, a bad decode or a write into the wrong slot. A readback shows such a fault one cycle after the address is presented. The derived outputs (counts, pick, lookup) show it immediately, because they are pure functions of the stored bits. A fault in the enable path or in the IRQ register appears at `virq` exactly one edge after the cause. The tests therefore check that pin on both sides of that edge, and they cover ties, priority 31, active-only entries and the ignored hardware flag.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int WORD_W   = 32;
  localparam int PR_W     = 5;
  localparam int PR_LO    = 23;
  localparam int ST_LO    = 28;
  localparam int CPU_W    = 3;
  localparam int CPU_LO   = 10;
  localparam int VID_W    = 10;
  localparam int HW_BIT   = 31;

  localparam int HCR_OFS  = 'h000;
  localparam int LR_OFS   = 'h100;
  localparam int LR_STEP  = 4;

  localparam logic [WORD_W-1:0] LR_KEEP  = 32'hFF88_1FFF;
  localparam logic [WORD_W-1:0] HCR_KEEP = 32'hF800_00FF;

  typedef logic [1:0] lr_state_t;
endpackage

// File: rtl/virq_lr_bank.sv
module virq_lr_bank
  import virq_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wdata,
  output logic [WORD_W-1:0]         rdata,
  output logic                      hcr_en,
  output lr_state_t [N-1:0]         st_o,
  output logic [N-1:0][PR_W-1:0]    pr_o,
  output logic [N-1:0][CPU_W-1:0]   cpu_o,
  output logic [N-1:0][VID_W-1:0]   vid_o
);
  logic [WORD_W-1:0] lr_q [N];
  logic [WORD_W-1:0] hcr_q;
  logic [WORD_W-1:0] rd_mux;

  localparam logic [ADDR_W-1:0] HCR_A = ADDR_W'(HCR_OFS);

  for (genvar gi = 0; gi < N; gi++) begin : g_entry
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(LR_OFS + LR_STEP * gi);
    always_ff @(posedge clk) begin
      if (rst)
        lr_q[gi] <= '0;
      else if (wr_en && addr == MY_A)
        lr_q[gi] <= wdata & LR_KEEP;
    end
    assign st_o[gi]  = lr_q[gi][ST_LO +: 2];
    assign pr_o[gi]  = lr_q[gi][PR_LO +: PR_W];
    assign cpu_o[gi] = lr_q[gi][CPU_LO +: CPU_W];
    assign vid_o[gi] = lr_q[gi][VID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      hcr_q <= '0;
    else if (wr_en && addr == HCR_A)
      hcr_q <= wdata & HCR_KEEP;
  end

  assign hcr_en = hcr_q[0];

  always_comb begin
    rd_mux = '0;
    if (addr == HCR_A) rd_mux = hcr_q;
    for (int i = 0; i < N; i++) begin
      if (addr == ADDR_W'(LR_OFS + LR_STEP * i)) rd_mux = lr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/virq_lr_stats.sv
module virq_lr_stats
  import virq_pkg::*;
#(
  parameter int N     = 4,
  parameter int CNT_W = 3
) (
  input  lr_state_t [N-1:0] st_i,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic [CNT_W-1:0]  valid_cnt
);
  always_comb begin
    pend_cnt  = '0;
    valid_cnt = '0;
    for (int i = 0; i < N; i++) begin
      pend_cnt  = pend_cnt  + CNT_W'(st_i[i][0]);
      valid_cnt = valid_cnt + CNT_W'(|st_i[i]);
    end
  end
endmodule

// File: rtl/virq_prio_pick.sv
module virq_prio_pick
  import virq_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  lr_state_t [N-1:0]      st_i,
  input  logic [N-1:0][PR_W-1:0] pr_i,
  output logic                   top_valid,
  output logic [IDX_W-1:0]       top_idx,
  output logic [PR_W-1:0]        top_prio
);
  // Ceiling one bit wider than any priority: every pending entry beats it.
  logic [PR_W:0] best;

  always_comb begin
    best    = '1;
    top_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (st_i[i][0] && ({1'b0, pr_i[i]} < best)) begin
        best    = {1'b0, pr_i[i]};
        top_idx = IDX_W'(i);
      end
    end
    top_valid = ~best[PR_W];
    top_prio  = top_valid ? best[PR_W-1:0] : '0;
  end
endmodule

// File: rtl/virq_lr_match.sv
module virq_lr_match
  import virq_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  lr_state_t [N-1:0]       st_i,
  input  logic [N-1:0][CPU_W-1:0] cpu_i,
  input  logic [N-1:0][VID_W-1:0] vid_i,
  input  logic [VID_W-1:0]        q_vid,
  input  logic [CPU_W-1:0]        q_cpu,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);
  logic [N-1:0] eq;

  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    assign eq[gi] = (|st_i[gi]) && (vid_i[gi] == q_vid) && (cpu_i[gi] == q_cpu);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i] && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/virq_list_ctrl.sv
module virq_list_ctrl
  import virq_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [VID_W-1:0]   q_vid,
  input  logic [CPU_W-1:0]   q_cpu,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               top_valid,
  output logic [IDX_W-1:0]   top_idx,
  output logic [PR_W-1:0]    top_prio,
  output logic [CNT_W-1:0]   pend_cnt,
  output logic [CNT_W-1:0]   valid_cnt,
  output logic               virq
);
  logic                      hcr_en;
  lr_state_t [N-1:0]         st;
  logic [N-1:0][PR_W-1:0]    pr;
  logic [N-1:0][CPU_W-1:0]   cpu;
  logic [N-1:0][VID_W-1:0]   vid;

  virq_lr_bank #(.N(N), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .hcr_en(hcr_en),
    .st_o(st), .pr_o(pr), .cpu_o(cpu), .vid_o(vid)
  );

  virq_lr_stats #(.N(N), .CNT_W(CNT_W)) u_stats (
    .st_i(st), .pend_cnt(pend_cnt), .valid_cnt(valid_cnt)
  );

  virq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .st_i(st), .pr_i(pr), .top_valid(top_valid),
    .top_idx(top_idx), .top_prio(top_prio)
  );

  virq_lr_match #(.N(N), .IDX_W(IDX_W)) u_match (
    .st_i(st), .cpu_i(cpu), .vid_i(vid), .q_vid(q_vid), .q_cpu(q_cpu),
    .hit(hit_o), .hit_idx(hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) virq <= 1'b0;
    else     virq <= hcr_en && (pend_cnt != '0);
  end
endmodule

// File: rtl/virq_list_ctrl_chk.sv
module virq_list_ctrl_chk
  import virq_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              hcr_en,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              hit_o,
  input logic [IDX_W-1:0]  hit_idx,
  input logic              top_valid,
  input logic [IDX_W-1:0]  top_idx,
  input logic [PR_W-1:0]   top_prio,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [CNT_W-1:0]  valid_cnt,
  input logic              virq
);
  localparam logic [WORD_W-1:0] NEVER_SET = ~(LR_KEEP | HCR_KEEP);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!virq && pend_cnt == '0 && valid_cnt == '0 && reg_rdata == '0));

  a_r8_virq_raise: assert property (@(posedge clk) disable iff (rst)
    (hcr_en && pend_cnt != '0) |=> virq);

  a_r8_virq_drop: assert property (@(posedge clk) disable iff (rst)
    !(hcr_en && pend_cnt != '0) |=> !virq);

  a_r5_pick_agrees_count: assert property (@(posedge clk) disable iff (rst)
    top_valid == (pend_cnt != '0));

  a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !top_valid |-> (top_idx == '0 && top_prio == '0));

  a_r4_valid_ge_pend: assert property (@(posedge clk) disable iff (rst)
    valid_cnt >= pend_cnt);

  a_r7_hit_needs_entry: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (valid_cnt != '0));

  a_r7_miss_idx_zero: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (hit_idx == '0));

  a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & NEVER_SET) == '0);
endmodule

bind virq_list_ctrl virq_list_ctrl_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .hcr_en(hcr_en), .reg_rdata(reg_rdata),
  .hit_o(hit_o), .hit_idx(hit_idx), .top_valid(top_valid),
  .top_idx(top_idx), .top_prio(top_prio), .pend_cnt(pend_cnt),
  .valid_cnt(valid_cnt), .virq(virq)
);

// File: tb/virq_list_ctrl_tb_top.sv
`timescale 1ns/1ps
module virq_list_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  q_vid = '0;
  logic [2:0]  q_cpu = '0;
  logic        hit_o, top_valid, virq;
  logic [1:0]  hit_idx, top_idx;
  logic [4:0]  top_prio;
  logic [2:0]  pend_cnt, valid_cnt;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  virq_list_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .q_vid(q_vid), .q_cpu(q_cpu),
    .hit_o(hit_o), .hit_idx(hit_idx), .top_valid(top_valid), .top_idx(top_idx),
    .top_prio(top_prio), .pend_cnt(pend_cnt), .valid_cnt(valid_cnt), .virq(virq)
  );

  function automatic logic [31:0] mk(input logic hw, input logic [1:0] st,
                                     input logic [4:0] pr, input logic [2:0] cpu,
                                     input logic [9:0] vid);
    return {hw, 1'b0, st, pr, 3'b000, 1'b0, 6'b000000, cpu, vid};
  endfunction

  function automatic logic [11:0] lra(input int i);
    return 12'(12'h100 + 4 * i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4; i++) wr(lra(i), 32'h0);
    wr(12'h000, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d); check("R1 hcr after reset", d, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rd(lra(i), d); check("R1 lr after reset", d, 32'h0);
    end
    check("R1 pend_cnt", 32'(pend_cnt), 0);
    check("R1 valid_cnt", 32'(valid_cnt), 0);
    check("R1 top_valid", 32'(top_valid), 0);
    check("R1 virq", 32'(virq), 0);
  endtask

  task automatic t_rw_mask();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr(lra(i), mk(0, 2'b00, 5'(i + 1), 3'(i), 10'(100 + i)));
    for (int i = 0; i < 4; i++) begin
      rd(lra(i), d); check("R2 lr readback", d, mk(0, 2'b00, 5'(i + 1), 3'(i), 10'(100 + i)));
    end
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); check("R3 hcr mask", d, 32'hF800_00FF);
    wr(12'h000, 32'h0);
    wr(lra(0), 32'hFFFF_FFFF);
    rd(lra(0), d); check("R3 lr mask", d, 32'hFF88_1FFF);
    wr(lra(0), 32'h0);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h104 + 12'h1, 32'hFFFF_FFFF);
    rd(12'h200, d); check("R3 unmapped read", d, 32'h0);
    rd(12'h0FC, d); check("R3 unmapped read 0fc", d, 32'h0);
    rd(lra(1), d); check("R3 unmapped write no effect", d, mk(0, 2'b00, 5'd2, 3'd1, 10'd101));
    rd(12'h000, d); check("R3 hcr untouched", d, 32'h0);
    clear_all();
  endtask

  task automatic t_counts_pick();
    wr(lra(0), mk(0, 2'b01, 5'd10, 3'd0, 10'd1));
    wr(lra(1), mk(0, 2'b10, 5'd0,  3'd0, 10'd2));
    wr(lra(2), mk(0, 2'b11, 5'd5,  3'd0, 10'd3));
    check("R4 pend_cnt", 32'(pend_cnt), 2);
    check("R4 valid_cnt", 32'(valid_cnt), 3);
    check("R5 top_valid", 32'(top_valid), 1);
    check("R9 active-only not picked idx", 32'(top_idx), 2);
    check("R5 top_prio", 32'(top_prio), 5);
    wr(lra(3), mk(0, 2'b01, 5'd4, 3'd0, 10'd4));
    check("R4 pend_cnt full", 32'(pend_cnt), 3);
    check("R4 valid_cnt full", 32'(valid_cnt), 4);
    check("R5 new top idx", 32'(top_idx), 3);
    clear_all();
    check("R5 none idx", 32'(top_idx), 0);
    check("R5 none prio", 32'(top_prio), 0);
  endtask

  task automatic t_tie();
    wr(lra(0), mk(0, 2'b01, 5'd9, 3'd0, 10'd1));
    wr(lra(1), mk(0, 2'b01, 5'd7, 3'd0, 10'd2));
    wr(lra(3), mk(0, 2'b01, 5'd7, 3'd0, 10'd3));
    check("R6 tie lower slot", 32'(top_idx), 1);
    check("R6 tie prio", 32'(top_prio), 7);
    clear_all();
    wr(lra(3), mk(0, 2'b01, 5'd31, 3'd0, 10'd3));
    check("R6 prio 31 valid", 32'(top_valid), 1);
    check("R6 prio 31 idx", 32'(top_idx), 3);
    check("R6 prio 31 value", 32'(top_prio), 31);
    clear_all();
  endtask

  task automatic t_lookup();
    wr(lra(0), mk(0, 2'b00, 5'd1, 3'd1, 10'd33));
    wr(lra(1), mk(0, 2'b10, 5'd1, 3'd2, 10'd33));
    wr(lra(2), mk(0, 2'b01, 5'd1, 3'd1, 10'd33));
    wr(lra(3), mk(0, 2'b10, 5'd1, 3'd1, 10'd33));
    @(negedge clk); q_vid = 10'd33; q_cpu = 3'd1; #1;
    check("R7 hit skips empty", 32'(hit_o), 1);
    check("R7 first match idx", 32'(hit_idx), 2);
    @(negedge clk); q_cpu = 3'd2; #1;
    check("R7 cpu match idx", 32'(hit_idx), 1);
    @(negedge clk); q_vid = 10'd34; q_cpu = 3'd1; #1;
    check("R7 miss", 32'(hit_o), 0);
    check("R7 miss idx", 32'(hit_idx), 0);
    clear_all();
  endtask

  task automatic t_virq();
    wr(12'h000, 32'h1);
    @(negedge clk);
    check("R8 enabled nothing pending", 32'(virq), 0);
    wr(lra(1), mk(0, 2'b10, 5'd2, 3'd0, 10'd9));
    @(negedge clk);
    check("R9 active-only no virq", 32'(virq), 0);
    wr(lra(2), mk(0, 2'b01, 5'd2, 3'd0, 10'd8));
    check("R8 registered lag", 32'(virq), 0);
    @(negedge clk);
    check("R8 virq raised", 32'(virq), 1);
    wr(12'h000, 32'h0);
    check("R8 still high one edge", 32'(virq), 1);
    @(negedge clk);
    check("R8 disabled drops", 32'(virq), 0);
    clear_all();
  endtask

  task automatic t_hw();
    logic [31:0] d;
    wr(lra(0), mk(1, 2'b01, 5'd3, 3'd0, 10'd5));
    wr(12'h000, 32'h1);
    rd(lra(0), d); check("R10 hw bit stored", d, mk(1, 2'b01, 5'd3, 3'd0, 10'd5));
    check("R10 pick unaffected", 32'(top_idx), 0);
    check("R10 prio unaffected", 32'(top_prio), 3);
    check("R10 pend unaffected", 32'(pend_cnt), 1);
    check("R10 virq unaffected", 32'(virq), 1);
    @(negedge clk); q_vid = 10'd5; q_cpu = 3'd0; #1;
    check("R10 lookup unaffected", 32'(hit_o), 1);
  endtask

  task automatic t_mid_reset();
    logic [31:0] d;
    wr(lra(3), mk(0, 2'b01, 5'd1, 3'd0, 10'd7));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 virq cleared", 32'(virq), 0);
    check("R1 counts cleared", 32'(valid_cnt), 0);
    rd(lra(3), d); check("R1 lr cleared", d, 32'h0);
    rd(12'h000, d); check("R1 hcr cleared", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rw_mask();
    t_counts_pick();
    t_tie();
    t_lookup();
    t_virq();
    t_hw();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule